// File: doc/BRIEF.md
# Transmit Interrupt Coalescing Timer

This block holds back the transmit-complete interrupt so that several finished transmit buffers can be reclaimed with a single notification. Each completion event carries two flags. One says that status reporting was requested. The other says that the interrupt may be delayed. When both flags are set, the completion arms a countdown. The countdown is measured in 1.024 µs units taken from a free-running prescaler on the core clock. Each further qualifying completion reloads the countdown. The interrupt fires only when a countdown runs out. A completion that asks for a report but not for a delay fires the interrupt at once.

Two other events also stop a pending countdown: an immediate interrupt and an absolute-timer interrupt, both raised elsewhere. Stopping the countdown keeps a stale, redundant interrupt from following them. Software sets the delay through a 32-bit register. The delay field is the low 16 bits and the other bits always read back as zero. A delay of zero is taken as one unit.

Top module: `txic_timer`

## Requirements
- R1: After reset the configuration read value is 0x00000000 and the interrupt output is low.
- R2: A register write stores bits 15:0 as the delay. Bits 31:16 always read as zero, whatever was written to them, including bit 31.
- R3: A completion with valid, report and delay all high starts a countdown of D units, where one unit is TICK_CYCLES clocks and D is the stored delay. The interrupt appears between (D-1)*TICK_CYCLES+1 and D*TICK_CYCLES clocks after the completion edge.
- R4: A qualifying completion that arrives while a countdown is running reloads it to D units, and no interrupt is produced from the earlier start.
- R5: The interrupt output is a one-clock pulse, and a single countdown produces exactly one pulse.
- R6: An immediate-interrupt or absolute-timer-interrupt input pulse stops a pending countdown, and no interrupt follows from it.
- R7: A completion with valid and report high and delay low raises the interrupt on the clock after the completion edge and stops any pending countdown.
- R8: A completion with report low, whatever its delay flag, neither starts nor fires the timer.
- R9: A stored delay of zero behaves as a delay of one unit.
- R10: When a qualifying completion and a countdown expiry fall in the same clock, the reload wins and no interrupt is produced in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the delay register |
| cfg_wr_data | input | 32 | Write data; bits 15:0 hold the delay |
| cfg_rd_data | output | 32 | Register read value; bits 31:16 are zero |
| cmp_valid | input | 1 | A transmit completion occurs this clock |
| cmp_report | input | 1 | The completion requests status reporting |
| cmp_delay | input | 1 | The completion allows a delayed interrupt |
| imm_irq | input | 1 | An immediate interrupt was raised elsewhere |
| abs_irq | input | 1 | The absolute timer raised an interrupt |
| txdone_irq | output | 1 | Transmit-complete interrupt, one-clock pulse |

## Verification
The bench builds the block with TICK_CYCLES set to 4, so one delay unit lasts four clocks. That makes full countdowns, reloads, cancellations and zero-delay expiries short enough to observe many times in one run. The bench does not model the prescaler phase. It checks each interrupt latency against a window one unit wide. A delay of one unit combined with a completion held high on every clock makes a reload coincide with an expiry at every tick, which exercises the reload-over-expiry priority.

// File: rtl/txic_pkg.sv
package txic_pkg;
  localparam int REG_W = 32;
  localparam int DLY_W = 16;

  // A zero delay is taken as one unit so the timer still fires.
  function automatic logic [DLY_W-1:0] eff_delay(input logic [DLY_W-1:0] v);
    return (v == '0) ? DLY_W'(1) : v;
  endfunction

  // Only the delay field is visible; every upper bit reads as zero.
  function automatic logic [REG_W-1:0] pack_read(input logic [DLY_W-1:0] v);
    return {{(REG_W-DLY_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/txic_tick_gen.sv
module txic_tick_gen #(
  parameter int TICK_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/txic_delay_reg.sv
module txic_delay_reg
  import txic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [DLY_W-1:0] load_val
);
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     dly_q <= '0;
    else if (wr_en) dly_q <= wr_data[DLY_W-1:0];
  end

  assign rd_data  = pack_read(dly_q);
  assign load_val = eff_delay(dly_q);
endmodule

// File: rtl/txic_countdown.sv
module txic_countdown
  import txic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             cancel,
  input  logic [DLY_W-1:0] load_val,
  output logic             running,
  output logic [DLY_W-1:0] count,
  output logic             expire
);
  logic last_unit;

  assign last_unit = (count == DLY_W'(1));
  // A reload or a cancel in the same clock suppresses the expiry.
  assign expire = running && tick && last_unit && !load && !cancel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
    end else if (load) begin
      running <= 1'b1;
      count   <= load_val;
    end else if (cancel) begin
      running <= 1'b0;
    end else if (running && tick) begin
      if (last_unit) running <= 1'b0;
      else           count   <= count - DLY_W'(1);
    end
  end
endmodule

// File: rtl/txic_timer.sv
module txic_timer
  import txic_pkg::*;
#(
  parameter int TICK_CYCLES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  input  logic        cmp_valid,
  input  logic        cmp_report,
  input  logic        cmp_delay,
  input  logic        imm_irq,
  input  logic        abs_irq,
  output logic        txdone_irq
);
  logic             tick;
  logic [DLY_W-1:0] load_val;
  logic             qual_load;
  logic             imm_fire;
  logic             cancel;
  logic             running;
  logic [DLY_W-1:0] count;
  logic             expire;
  logic             irq_q;

  assign qual_load = cmp_valid && cmp_report && cmp_delay;
  assign imm_fire  = cmp_valid && cmp_report && !cmp_delay;
  assign cancel    = imm_irq || abs_irq || imm_fire;

  txic_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  txic_delay_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .load_val(load_val)
  );

  txic_countdown u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (qual_load),
    .cancel  (cancel),
    .load_val(load_val),
    .running (running),
    .count   (count),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= expire || imm_fire;
  end

  assign txdone_irq = irq_q;
endmodule

// File: rtl/txic_timer_chk.sv
module txic_timer_chk
  import txic_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      cfg_rd_data,
  input logic             txdone_irq,
  input logic             qual_load,
  input logic             imm_fire,
  input logic             cancel,
  input logic             expire,
  input logic             running,
  input logic [DLY_W-1:0] count
);
  // R3: a qualifying completion leaves the timer armed
  a_r3_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    qual_load |=> running);

  // R10: a reload is never followed by an interrupt in the next clock
  a_r10_reload_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    qual_load |=> !txdone_irq);

  // R6: a cancel without a reload leaves the timer stopped
  a_r6_cancel_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !qual_load) |=> !running);

  // R5: every pulse comes from an expiry or an immediate completion
  a_r5_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    txdone_irq |-> $past(expire || imm_fire));

  // R8: an idle timer without an immediate completion stays quiet
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !imm_fire) |=> !txdone_irq);

  // R9: an armed timer never holds a zero count
  a_r9_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (count != '0));

  // R2: upper register bits read as zero
  always @(posedge clk) begin
    if (rst_n) a_r2_upper_zero: assert (cfg_rd_data[31:16] == 16'h0);
  end
endmodule

bind txic_timer txic_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_rd_data(cfg_rd_data),
  .txdone_irq (txdone_irq),
  .qual_load  (qual_load),
  .imm_fire   (imm_fire),
  .cancel     (cancel),
  .expire     (expire),
  .running    (running),
  .count      (count)
);

// File: tb/txic_timer_test.sv
module txic_timer_test;
  localparam int PERIOD = 10;
  localparam int T      = 4;
  localparam int NV     = 6;
  localparam logic [31:0] WV    [NV] = '{32'h0000_0001, 32'h0000_0002, 32'hFFFF_0003,
                                         32'h8000_0005, 32'h0000_0000, 32'h7FF0_0004};
  localparam logic [31:0] RV    [NV] = '{32'h0000_0001, 32'h0000_0002, 32'h0000_0003,
                                         32'h0000_0005, 32'h0000_0000, 32'h0000_0004};
  localparam int          NEFF  [NV] = '{1, 2, 3, 5, 1, 4};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        cmp_valid = 1'b0, cmp_report = 1'b0, cmp_delay = 1'b0;
  logic        imm_irq = 1'b0, abs_irq = 1'b0;
  logic        txdone_irq;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  txic_timer #(.TICK_CYCLES(T)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cmp_valid(cmp_valid), .cmp_report(cmp_report),
    .cmp_delay(cmp_delay), .imm_irq(imm_irq), .abs_irq(abs_irq), .txdone_irq(txdone_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  // Drives one completion for one clock; returns at the following falling edge.
  task automatic completion(input logic rep, input logic dly);
    @(negedge clk); cmp_valid = 1'b1; cmp_report = rep; cmp_delay = dly;
    @(negedge clk); cmp_valid = 1'b0; cmp_report = 1'b0; cmp_delay = 1'b0;
  endtask

  task automatic pulse_cancel(input logic use_abs);
    @(negedge clk); imm_irq = !use_abs; abs_irq = use_abs;
    @(negedge clk); imm_irq = 1'b0; abs_irq = 1'b0;
  endtask

  // Counts clocks until the interrupt is seen; returns limit+1 if it never comes.
  task automatic wait_irq(input int limit, output int lat);
    lat = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      if (i > 1 || 1) @(negedge clk);
      if (txdone_irq) begin lat = i; break; end
    end
  endtask

  task automatic count_irqs(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txdone_irq) n++;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    int lat, n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 read after reset", cfg_rd_data, 32'h0);
    check("R1 irq after reset", {31'b0, txdone_irq}, 32'h0);
    rst_n = 1'b1;
    count_irqs(3 * T, n);
    check("R1 no irq when idle", n, 0);

    // Table walk: R2 readback, R3 latency, R9 zero delay, R5 single pulse
    for (int v = 0; v < NV; v++) begin
      write_reg(WV[v]);
      check("R2 readback", cfg_rd_data, RV[v]);
      completion(1'b1, 1'b1);
      wait_irq(NEFF[v] * T + 2, lat);
      if (WV[v][15:0] == 16'h0)
        check_range("R9 zero delay latency", lat, 1, T);
      else
        check_range("R3 countdown latency", lat, (NEFF[v] - 1) * T + 1, NEFF[v] * T);
      count_irqs(3 * T, n);
      check("R5 one pulse per countdown", n, 0);
    end

    // R4: reload while running
    write_reg(32'h3);
    completion(1'b1, 1'b1);
    count_irqs(2 * T - 1, n);
    completion(1'b1, 1'b1);
    check("R4 no irq before reload", n, 0);
    wait_irq(3 * T + 2, lat);
    check_range("R4 latency from reload", lat, 2 * T + 1, 3 * T);
    count_irqs(3 * T, n);
    check("R4 single pulse after reload", n, 0);

    // R6: absolute and immediate cancels
    write_reg(32'h5);
    completion(1'b1, 1'b1);
    count_irqs(2 * T, n);
    pulse_cancel(1'b1);
    count_irqs(6 * T, n);
    check("R6 abs cancel suppresses irq", n, 0);
    completion(1'b1, 1'b1);
    count_irqs(T, n);
    pulse_cancel(1'b0);
    count_irqs(6 * T, n);
    check("R6 imm cancel suppresses irq", n, 0);

    // R7: report without delay fires at once and cancels pending
    completion(1'b1, 1'b1);
    count_irqs(T, n);
    completion(1'b1, 1'b0);
    check("R7 immediate irq", {31'b0, txdone_irq}, 32'h1);
    @(negedge clk);
    check("R5 immediate pulse one clock", {31'b0, txdone_irq}, 32'h0);
    count_irqs(6 * T, n);
    check("R7 pending countdown cancelled", n, 0);

    // R8: completions without report are ignored
    write_reg(32'h2);
    completion(1'b0, 1'b1);
    completion(1'b0, 1'b0);
    count_irqs(4 * T, n);
    check("R8 no report no irq", n, 0);

    // R10: continuous reloads with a one-unit delay never expire
    write_reg(32'h1);
    @(negedge clk); cmp_valid = 1'b1; cmp_report = 1'b1; cmp_delay = 1'b1;
    count_irqs(10 * T, n);
    cmp_valid = 1'b0; cmp_report = 1'b0; cmp_delay = 1'b0;
    check("R10 reload beats expiry", n, 0);
    wait_irq(T + 2, lat);
    check_range("R10 expiry after reloads stop", lat, 1, T);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule